// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block gives software a word-wide register port onto up to six banks of 32 general-purpose pins. Each pin has a direction bit and an output latch. Its level is read back through a two-stage synchronizer. Rising and falling transitions are caught in a sticky per-bank status word. The output latch is never written directly. Software raises pins through a set strobe register and lowers them through a clear strobe register, so a single write touches only the selected bits and needs no read-modify-write.

The register file is grouped by register kind rather than by bank. Three consecutive words of one kind serve three banks, and banks three to five repeat the pattern 0x100 bytes higher. A per-bank gate word decides which latched status bits become visible and may raise the single combined interrupt. A parameter can reverse the polarity of the direction bit for selected pins, and the last bank may carry fewer than 32 live pins.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: A register sits at kind base plus bank offset. The kind bases are level 0x00, direction 0x0C, set 0x18, clear 0x24, rise enable 0x30, fall enable 0x3C, status 0x48 and gate 0x9C. The bank offset is 4*n for banks 0..2 and 0x100 + 4*(n-3) for banks 3..5. Pin p of a bank is bit p of each word.
- R2: Writing the set word drives the output latch high on every bit written as 1. Writing the clear word drives it low on every bit written as 1. Bits written as 0 leave the latch as it was, and padOut shows the latch on the clock after the write.
- R3: A direction bit of 1 makes the pin an output (padOe high), except for pins named in DIR_INVERT, where a direction bit of 0 selects output. After reset every pin is an input, so the direction word reads 1 on inverted pins and 0 elsewhere.
- R4: The level word returns the pad input after a two-flop synchronizer. A pad change is seen in the level word after the second rising clock edge and not after the first.
- R5: A status bit is set when its pin's synchronized level goes 0 to 1 while rise enable is 1, or 1 to 0 while fall enable is 1. The bit becomes readable after the third clock edge that follows the pad change. An edge whose enable is 0 sets nothing.
- R6: Writing 1 to a status bit clears it, and writing 0 leaves it alone. If an edge reaches a bit on the same clock as a clearing write, the bit stays set.
- R7: The status word reads as latched status AND gate. The interrupt output is the OR of these gated bits over all banks. Status keeps latching while the gate is 0 and appears once the gate is set.
- R8: Bits above the last live pin of the last bank read 0 in every word, and writes do not change them.
- R9: Reads of any address not in R1 return 0, including misaligned addresses, addresses with bit 9 or above set, and banks beyond the configured count. Writes to such addresses change nothing, and writes to the level word are ignored.
- R10: After reset the output latches, enables, status and gate words are 0, padOut and padOe are 0, and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | ADDR_W | Byte address of the register access |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| padIn | input | NUM_PINS | Sensed pad levels |
| padOut | output | NUM_PINS | Output latch values |
| padOe | output | NUM_PINS | Output enable per pin |
| irq | output | 1 | OR of all gated status bits |

## Verification
The one pair of functions that can act on the same cycle is a software clear of a status bit and a new hardware edge on that same bit. The bench places the pad transition exactly two clocks before the clearing write, so that the edge reaches the status register on the clock that commits the write. It then expects the bit to read back as 1. A design that gives the clear priority reads 0 and is reported.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int WORD_W    = 32;
  localparam int MAX_BANKS = 6;
  localparam int NUM_SEL   = 8;

  typedef enum logic [2:0] {
    SEL_LEVEL = 3'd0,
    SEL_DIR   = 3'd1,
    SEL_SET   = 3'd2,
    SEL_CLR   = 3'd3,
    SEL_RISE  = 3'd4,
    SEL_FALL  = 3'd5,
    SEL_STAT  = 3'd6,
    SEL_GATE  = 3'd7
  } regSel_e;

  // Strobes handed from the decoder to every bank datapath
  typedef struct packed {
    logic    hit;
    logic    wr;
    logic [2:0] bank;
    regSel_e sel;
  } busAccess_t;

  // Byte offset of each register kind within a group of three banks
  function automatic logic [7:0] selBase(input int s);
    case (s)
      0:       selBase = 8'h00;
      1:       selBase = 8'h0C;
      2:       selBase = 8'h18;
      3:       selBase = 8'h24;
      4:       selBase = 8'h30;
      5:       selBase = 8'h3C;
      6:       selBase = 8'h48;
      default: selBase = 8'h9C;
    endcase
  endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int NUM_BANKS = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  output busAccess_t        acc
);

  localparam int GROUP_BIT = 8;
  localparam int SPAN      = 12;

  logic [7:0] lowAddr;
  logic [7:0] diff;
  logic       kindFound;
  regSel_e    kindSel;
  logic [1:0] slot;
  logic [2:0] bankNum;
  logic       upperZero;
  logic       aligned;
  logic       inRange;

  assign lowAddr   = addr[7:0];
  assign upperZero = ((addr >> (GROUP_BIT + 1)) == '0);
  assign aligned   = (addr[1:0] == 2'b00);

  always_comb begin
    kindFound = 1'b0;
    kindSel   = SEL_LEVEL;
    slot      = 2'd0;
    diff      = 8'd0;
    for (int s = 0; s < NUM_SEL; s++) begin
      diff = lowAddr - selBase(s);
      if ((lowAddr >= selBase(s)) && (diff < 8'(SPAN))) begin
        kindFound = 1'b1;
        kindSel   = regSel_e'(s);
        slot      = diff[3:2];
      end
    end
  end

  assign bankNum = addr[GROUP_BIT] ? (3'd3 + {1'b0, slot}) : {1'b0, slot};
  assign inRange = (32'(bankNum) < NUM_BANKS);

  always_comb begin
    acc.hit  = kindFound && aligned && upperZero && inRange;
    acc.wr   = acc.hit && wrEn;
    acc.bank = bankNum;
    acc.sel  = kindSel;
  end

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] lvlPrev
);

  logic [WIDTH-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gStage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[g] <= '0;
        else if (g == 0) chain[g] <= padIn;
        else chain[g] <= chain[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lvlPrev <= '0;
    else lvlPrev <= chain[STAGES-1];
  end

  assign lvl = chain[STAGES-1];

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int          BANK_IDX = 0,
  parameter int          LIVE     = 32,
  parameter logic [31:0] INV      = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  busAccess_t       acc,
  input  logic [31:0]      wrData,
  input  logic [LIVE-1:0]  padIn,
  output logic [LIVE-1:0]  padOut,
  output logic [LIVE-1:0]  padOe,
  output logic [31:0]      rdWord,
  output logic             irqBank
);

  localparam logic [31:0] LIVE_MASK = (LIVE >= 32) ? 32'hFFFF_FFFF
                                                   : ((32'd1 << LIVE) - 32'd1);
  localparam logic [31:0] INV_LIVE  = INV & LIVE_MASK;

  logic [31:0] outLat, dirReg, riseEn, fallEn, stat, gate;
  logic [LIVE-1:0] lvlNarrow, prevNarrow;
  logic [31:0] lvl, lvlPrev;
  logic [31:0] riseHit, fallHit, evt, clrMask, wMasked;
  logic wrHere, wrSet, wrClr, wrDir, wrRise, wrFall, wrStat, wrGate;

  gpio_pin_sync #(.WIDTH(LIVE), .STAGES(2)) uSync (
    .clk    (clk),
    .rstN   (rstN),
    .padIn  (padIn),
    .lvl    (lvlNarrow),
    .lvlPrev(prevNarrow)
  );

  assign lvl     = 32'(lvlNarrow);
  assign lvlPrev = 32'(prevNarrow);

  assign wrHere = acc.wr && (acc.bank == 3'(BANK_IDX));
  assign wrSet  = wrHere && (acc.sel == SEL_SET);
  assign wrClr  = wrHere && (acc.sel == SEL_CLR);
  assign wrDir  = wrHere && (acc.sel == SEL_DIR);
  assign wrRise = wrHere && (acc.sel == SEL_RISE);
  assign wrFall = wrHere && (acc.sel == SEL_FALL);
  assign wrStat = wrHere && (acc.sel == SEL_STAT);
  assign wrGate = wrHere && (acc.sel == SEL_GATE);

  assign wMasked = wrData & LIVE_MASK;
  assign riseHit = lvl & ~lvlPrev & riseEn;
  assign fallHit = ~lvl & lvlPrev & fallEn;
  assign evt     = riseHit | fallHit;
  assign clrMask = wrStat ? wMasked : 32'd0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outLat <= '0;
      dirReg <= INV_LIVE;
      riseEn <= '0;
      fallEn <= '0;
      stat   <= '0;
      gate   <= '0;
    end else begin
      if (wrSet)       outLat <= outLat | wMasked;
      else if (wrClr)  outLat <= outLat & ~wMasked;
      if (wrDir)  dirReg <= wMasked;
      if (wrRise) riseEn <= wMasked;
      if (wrFall) fallEn <= wMasked;
      if (wrGate) gate   <= wMasked;
      stat <= ((stat & ~clrMask) | evt) & LIVE_MASK;
    end
  end

  logic [31:0] oeWide;
  assign oeWide = (dirReg ^ INV) & LIVE_MASK;
  assign padOe  = oeWide[LIVE-1:0];
  assign padOut = outLat[LIVE-1:0];

  always_comb begin
    case (acc.sel)
      SEL_LEVEL: rdWord = lvl;
      SEL_DIR:   rdWord = dirReg;
      SEL_SET:   rdWord = outLat;
      SEL_CLR:   rdWord = outLat;
      SEL_RISE:  rdWord = riseEn;
      SEL_FALL:  rdWord = fallEn;
      SEL_STAT:  rdWord = stat & gate;
      default:   rdWord = gate;
    endcase
  end

  assign irqBank = |(stat & gate);

  AST_SET_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    wrSet |=> ((32'(padOut) & $past(wMasked)) == $past(wMasked))) // R2
    else $error("set strobe did not raise latch");

  AST_CLR_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    wrClr |=> ((32'(padOut) & $past(wMasked)) == 32'd0)) // R2
    else $error("clear strobe did not lower latch");

  AST_DIR_OE: assert property (@(posedge clk) disable iff (!rstN)
    wrDir |=> (32'(padOe) == (($past(wMasked) ^ INV) & LIVE_MASK))) // R3
    else $error("output enable does not follow direction write");

  AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (evt != 32'd0) |=> ((stat & $past(evt & LIVE_MASK)) == $past(evt & LIVE_MASK))) // R6
    else $error("edge event lost");

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (wrStat && (evt == 32'd0)) |=> ((stat & $past(wMasked)) == 32'd0)) // R6
    else $error("write-one-to-clear left a bit set");

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int           NUM_PINS   = 190,
  parameter int           ADDR_W     = 10,
  parameter logic [191:0] DIR_INVERT = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [31:0]         busWrData,
  output logic [31:0]         busRdData,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic                irq
);

  localparam int NUM_BANKS = (NUM_PINS + WORD_W - 1) / WORD_W;

  busAccess_t  acc;
  logic [31:0] bankRd  [NUM_BANKS];
  logic [NUM_BANKS-1:0] bankIrq;

  gpio_addr_dec #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) uDec (
    .addr (busAddr),
    .wrEn (busWrEn),
    .acc  (acc)
  );

  genvar b;
  generate
    for (b = 0; b < NUM_BANKS; b++) begin : gBank
      localparam int LIVE = (b == NUM_BANKS - 1) ? (NUM_PINS - WORD_W * b) : WORD_W;
      gpio_bank #(
        .BANK_IDX (b),
        .LIVE     (LIVE),
        .INV      (DIR_INVERT[b*WORD_W +: WORD_W])
      ) uBank (
        .clk     (clk),
        .rstN    (rstN),
        .acc     (acc),
        .wrData  (busWrData),
        .padIn   (padIn [b*WORD_W +: LIVE]),
        .padOut  (padOut[b*WORD_W +: LIVE]),
        .padOe   (padOe [b*WORD_W +: LIVE]),
        .rdWord  (bankRd[b]),
        .irqBank (bankIrq[b])
      );
    end
  endgenerate

  always_comb begin
    busRdData = 32'd0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (acc.hit && (acc.bank == 3'(i))) busRdData = bankRd[i];
    end
  end

  assign irq = |bankIrq;

endmodule

// File: tb/tb_gpio_bank_ctrl.sv
module tb_gpio_bank_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NPINS = 190;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [9:0] busAddr = '0;
  logic busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [NPINS-1:0] padIn = '0;
  logic [NPINS-1:0] padOut, padOe;
  logic irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] rd;

  gpio_bank_ctrl #(
    .NUM_PINS   (NPINS),
    .ADDR_W     (10),
    .DIR_INVERT (192'hF << 86)
  ) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [9:0] regAddr(input logic [7:0] base, input int bank);
    logic [9:0] off;
    off = (bank < 3) ? 10'(bank * 4) : 10'(256 + (bank - 3) * 4);
    return off + 10'(base);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // caller stands at a falling edge; returns at the next one
  task automatic writeReg(input logic [9:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [9:0] a, output logic [31:0] v);
    busAddr = a;
    #1;
    v = busRdData;
  endtask

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tReset;
    check("R10 padOe", 32'(padOe[31:0]), 32'h0);
    check("R10 padOut", 32'(padOut[31:0]), 32'h0);
    check("R10 irq", 32'(irq), 32'h0);
    readReg(regAddr(8'h48, 0), rd); check("R10 status", rd, 32'h0);
    readReg(regAddr(8'h0C, 0), rd); check("R3 reset dir bank0", rd, 32'h0);
    readReg(regAddr(8'h0C, 2), rd); check("R3 reset dir inverted", rd, 32'h03C0_0000);
    check("R3 reset padOe bank2", padOe[95:64], 32'h0);
  endtask

  task automatic tSetClr;
    writeReg(regAddr(8'h18, 0), 32'h0000_00A5);
    check("R2 set", padOut[31:0], 32'h0000_00A5);
    writeReg(regAddr(8'h18, 0), 32'h0000_0100);
    check("R2 set keeps zeros", padOut[31:0], 32'h0000_01A5);
    writeReg(regAddr(8'h24, 0), 32'h0000_0021);
    check("R2 clear", padOut[31:0], 32'h0000_0184);
    writeReg(regAddr(8'h18, 4), 32'hFFFF_0000);
    check("R1 bank4 set", padOut[159:128], 32'hFFFF_0000);
    check("R1 bank0 untouched", padOut[31:0], 32'h0000_0184);
  endtask

  task automatic tDir;
    writeReg(regAddr(8'h0C, 2), 32'h03C0_0001);
    check("R3 inverted pins off", padOe[95:64], 32'h0000_0001);
    writeReg(regAddr(8'h0C, 2), 32'h0);
    check("R3 inverted pins out", padOe[95:64], 32'h03C0_0000);
    writeReg(regAddr(8'h0C, 2), 32'h03C0_0000);
  endtask

  task automatic tLevel;
    padIn[63:32] = 32'h1234_5678;
    waitNeg(1);
    readReg(regAddr(8'h00, 1), rd); check("R4 level after one edge", rd, 32'h0);
    waitNeg(1);
    readReg(regAddr(8'h00, 1), rd); check("R4 level after two edges", rd, 32'h1234_5678);
  endtask

  task automatic tEdge;
    writeReg(regAddr(8'h9C, 0), 32'hFFFF_FFFF);
    writeReg(regAddr(8'h30, 0), 32'h1);
    writeReg(regAddr(8'h3C, 0), 32'h2);
    padIn[1:0] = 2'b11;
    waitNeg(2);
    readReg(regAddr(8'h48, 0), rd); check("R5 not yet after two edges", rd, 32'h0);
    waitNeg(1);
    readReg(regAddr(8'h48, 0), rd); check("R5 rise only where enabled", rd, 32'h1);
    check("R7 irq raised", 32'(irq), 32'h1);
    padIn[1] = 1'b0;
    waitNeg(3);
    readReg(regAddr(8'h48, 0), rd); check("R5 fall captured", rd, 32'h3);
  endtask

  task automatic tW1c;
    writeReg(regAddr(8'h48, 0), 32'h1);
    readReg(regAddr(8'h48, 0), rd); check("R6 clear one bit", rd, 32'h2);
    writeReg(regAddr(8'h48, 0), 32'h2);
    readReg(regAddr(8'h48, 0), rd); check("R6 clear other bit", rd, 32'h0);
    check("R7 irq low after clear", 32'(irq), 32'h0);
  endtask

  task automatic tCollide;
    padIn[0] = 1'b0;
    waitNeg(4);
    readReg(regAddr(8'h48, 0), rd); check("R5 disabled fall ignored", rd, 32'h0);
    padIn[0] = 1'b1;
    waitNeg(2);
    writeReg(regAddr(8'h48, 0), 32'h1);
    readReg(regAddr(8'h48, 0), rd); check("R6 edge beats clear", rd, 32'h1);
  endtask

  task automatic tGate;
    writeReg(regAddr(8'h9C, 0), 32'h0);
    readReg(regAddr(8'h48, 0), rd); check("R7 gated status hidden", rd, 32'h0);
    check("R7 gated irq low", 32'(irq), 32'h0);
    writeReg(regAddr(8'h9C, 0), 32'hFFFF_FFFF);
    readReg(regAddr(8'h48, 0), rd); check("R7 status reappears", rd, 32'h1);
    check("R7 irq back", 32'(irq), 32'h1);
    writeReg(regAddr(8'h48, 0), 32'hFFFF_FFFF);
  endtask

  task automatic tDead;
    writeReg(regAddr(8'h18, 5), 32'hFFFF_FFFF);
    check("R8 live pins set", 32'(padOut[189:160]), 32'h3FFF_FFFF);
    writeReg(regAddr(8'h0C, 5), 32'hFFFF_FFFF);
    readReg(regAddr(8'h0C, 5), rd); check("R8 dead dir bits zero", rd, 32'h3FFF_FFFF);
    readReg(regAddr(8'h18, 5), rd); check("R8 dead latch bits zero", rd, 32'h3FFF_FFFF);
    check("R8 live oe", 32'(padOe[189:160]), 32'h3FFF_FFFF);
  endtask

  task automatic tUnmapped;
    writeReg(10'h060, 32'hFFFF_FFFF);
    check("R9 hole write ignored", padOut[31:0], 32'h0000_0184);
    check("R9 hole write oe", padOe[31:0], 32'h0);
    readReg(10'h060, rd); check("R9 hole reads zero", rd, 32'h0);
    readReg(10'h001, rd); check("R9 misaligned reads zero", rd, 32'h0);
    readReg(10'h200, rd); check("R9 high address reads zero", rd, 32'h0);
    writeReg(regAddr(8'h00, 0), 32'hFFFF_FFFF);
    check("R9 level write ignored", padOut[31:0], 32'h0000_0184);
    readReg(regAddr(8'h00, 0), rd); check("R9 level still pads", rd, 32'h1);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    waitNeg(3);
    rstN = 1'b1;
    waitNeg(1);
    tReset();
    tSetClr();
    tDir();
    tLevel();
    tEdge();
    tW1c();
    tCollide();
    tGate();
    tDead();
    tUnmapped();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule